// File: doc/BRIEF.md
# Write Preamble and Sync-Mark Sequencer

This block sits in the write path of a disk read channel, just ahead of the run-length encoder. While write gate is high it watches the byte-wide NRZ input on every byte-time strobe. For each byte it picks what goes to the encoder: the timing-acquisition field (00h), equalizer training bytes (93h), one or two sync marks (1Fh, 69h), and then user data passed straight through. Each output byte carries a phase tag, so the scrambler and encoder further down the path know which bytes are user data.

In manual mode the controller supplies the training and sync bytes itself. 93h ends the timing field, and the block tracks the controller's sequence for either single or dual sync detection. In semi-automatic mode an FFh trigger ends the timing field, and the block then produces a fixed run of training bytes and one sync mark on its own. When the first training byte goes out, the block can also pulse a strobe that presets or resets the downstream precoder. Whether it pulses, and with which value, depends on the configuration inputs.

Top module: `wr_preamble_seq`

## Requirements
- R1: After reset, `out_byte_o`=00h, `phase_o`=0 (timing field), and `data_valid_o` and `pc_init_stb_o` are both 0. Phase codes: 0 timing field, 1 training, 2 sync mark, 3 data.
- R2: In the timing-field state, each byte strobe whose NRZ byte is not the active trigger outputs 00h with phase 0.
- R3: In manual mode (`semi_auto_i`=0), a 93h byte ends the timing field and is output as 93h with phase 1. During training, any byte that does not advance the sequence is output as 93h with phase 1.
- R4: In manual single-sync mode (`dual_sync_i`=0), a 69h byte during training is output as 69h with phase 2, and the block then enters data mode. In this mode a 1Fh byte during training is treated as training.
- R5: In manual dual-sync mode, a 1Fh byte during training is output as 1Fh with phase 2. The next byte is output as 93h with phase 1, whatever its value. Later bytes are output as 93h with phase 1 until a 69h byte, which is output as 69h with phase 2 and leads into data mode. In this mode a 69h byte during training is treated as training.
- R6: In semi-automatic mode, only FFh ends the timing field and 93h does not. After FFh the block outputs 93h with phase 1 for exactly 5 byte times, the trigger byte included, and then 69h with phase 2 for one byte time, whatever the NRZ input is. Then it enters data mode. In manual mode FFh does not end the timing field.
- R7: In data mode each NRZ byte is output unchanged with phase 3 and `data_valid_o`=1.
- R8: When `wg_i` is low at a clock edge, the outputs return to the R1 values at that edge and the sequencer returns to the timing-field state, whatever state it was in.
- R9: When `test_mode_i`=0 and `pc_preset_dis_i`=0, `pc_init_stb_o` is high for exactly one clock cycle, in the cycle the first training byte appears. `pc_init_val_o` then equals `pc_pol_i` (1 preset, 0 reset).
- R10: When either `test_mode_i` or `pc_preset_dis_i` is 1, `pc_init_stb_o` stays 0.
- R11: While `wg_i` is high, the outputs change only at a clock edge where `byte_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_en_i | input | 1 | Byte-time clock enable |
| wg_i | input | 1 | Write gate |
| nrz_i | input | 8 | NRZ byte from the controller |
| semi_auto_i | input | 1 | 1 selects semi-automatic mode |
| dual_sync_i | input | 1 | 1 selects dual sync marks (manual mode only) |
| test_mode_i | input | 1 | Test mode bit; 1 blocks the precoder preset |
| pc_preset_dis_i | input | 1 | Precoder preset disable |
| pc_pol_i | input | 1 | Precoder initial value: 1 preset, 0 reset |
| out_byte_o | output | 8 | Byte to the encoder |
| phase_o | output | 2 | Phase tag of the output byte |
| data_valid_o | output | 1 | Output byte is user data |
| pc_init_stb_o | output | 1 | One-cycle precoder init strobe |
| pc_init_val_o | output | 1 | Precoder init value, valid with the strobe |

## Verification
The properties assume the configuration inputs (mode, sync count, test, disable, polarity) stay constant for a whole write-gate window. The precoder-enable check compares against the previous cycle's configuration, so it relies on this. The properties also assume `byte_en_i` is a single-cycle pulse. The stimulus changes the configuration only while write gate is low, and it drives every byte strobe as a one-cycle pulse followed by an idle cycle. This spacing also lets the property for R11 observe output stability between strobes.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] VCO_CODE   = 8'h00;
  localparam logic [BYTE_W-1:0] TRAIN_CODE = 8'h93;
  localparam logic [BYTE_W-1:0] MARK1_CODE = 8'h1F;
  localparam logic [BYTE_W-1:0] MARK_CODE  = 8'h69;
  localparam logic [BYTE_W-1:0] AUTO_CODE  = 8'hFF;

  typedef enum logic [1:0] {
    PH_VCO   = 2'd0,
    PH_TRAIN = 2'd1,
    PH_MARK  = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    ST_VCO,
    ST_TRAIN,
    ST_DS_PROP,
    ST_DS_TAIL,
    ST_AUTO,
    ST_DATA
  } st_e;
endpackage

// File: rtl/wps_trig_det.sv
module wps_trig_det
  import wps_pkg::*;
(
  input  logic [BYTE_W-1:0] nrz_i,
  output logic              hit_train_o,
  output logic              hit_mark1_o,
  output logic              hit_mark_o,
  output logic              hit_auto_o
);
  assign hit_train_o = (nrz_i == TRAIN_CODE);
  assign hit_mark1_o = (nrz_i == MARK1_CODE);
  assign hit_mark_o  = (nrz_i == MARK_CODE);
  assign hit_auto_o  = (nrz_i == AUTO_CODE);
endmodule

// File: rtl/wps_auto_cnt.sv
module wps_auto_cnt #(
  parameter int LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= CW'(1);
    else if (inc_i) cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = (cnt_q == CW'(LEN));
endmodule

// File: rtl/wps_ctrl.sv
module wps_ctrl
  import wps_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_en_i,
  input  logic              wg_i,
  input  logic [BYTE_W-1:0] nrz_i,
  input  logic              semi_auto_i,
  input  logic              dual_sync_i,
  input  logic              preset_en_i,
  input  logic              pc_pol_i,
  input  logic              hit_train_i,
  input  logic              hit_mark1_i,
  input  logic              hit_mark_i,
  input  logic              hit_auto_i,
  input  logic              cnt_done_i,
  output logic              cnt_ld_o,
  output logic              cnt_inc_o,
  output logic [BYTE_W-1:0] out_byte_o,
  output phase_e            phase_o,
  output logic              data_valid_o,
  output logic              pc_init_stb_o,
  output logic              pc_init_val_o
);
  st_e               st_q, st_d;
  logic [BYTE_W-1:0] byte_d;
  phase_e            ph_d;
  logic              stb_d, ld_d, inc_d;

  always_comb begin
    st_d   = st_q;
    byte_d = TRAIN_CODE;
    ph_d   = PH_TRAIN;
    stb_d  = 1'b0;
    ld_d   = 1'b0;
    inc_d  = 1'b0;
    unique case (st_q)
      ST_VCO: begin
        if (semi_auto_i ? hit_auto_i : hit_train_i) begin
          st_d  = semi_auto_i ? ST_AUTO : ST_TRAIN;
          ld_d  = semi_auto_i;
          stb_d = preset_en_i;
        end else begin
          byte_d = VCO_CODE;
          ph_d   = PH_VCO;
        end
      end
      ST_TRAIN: begin
        if (!dual_sync_i && hit_mark_i) begin
          byte_d = MARK_CODE;
          ph_d   = PH_MARK;
          st_d   = ST_DATA;
        end else if (dual_sync_i && hit_mark1_i) begin
          byte_d = MARK1_CODE;
          ph_d   = PH_MARK;
          st_d   = ST_DS_PROP;
        end
      end
      ST_DS_PROP: st_d = ST_DS_TAIL;
      ST_DS_TAIL: begin
        if (hit_mark_i) begin
          byte_d = MARK_CODE;
          ph_d   = PH_MARK;
          st_d   = ST_DATA;
        end
      end
      ST_AUTO: begin
        if (cnt_done_i) begin
          byte_d = MARK_CODE;
          ph_d   = PH_MARK;
          st_d   = ST_DATA;
        end else begin
          inc_d = 1'b1;
        end
      end
      ST_DATA: begin
        byte_d = nrz_i;
        ph_d   = PH_DATA;
      end
      default: st_d = ST_VCO;
    endcase
  end

  assign cnt_ld_o  = wg_i && byte_en_i && ld_d;
  assign cnt_inc_o = wg_i && byte_en_i && inc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_VCO;
      out_byte_o    <= VCO_CODE;
      phase_o       <= PH_VCO;
      data_valid_o  <= 1'b0;
      pc_init_stb_o <= 1'b0;
      pc_init_val_o <= 1'b0;
    end else begin
      pc_init_stb_o <= 1'b0;
      if (!wg_i) begin
        st_q         <= ST_VCO;
        out_byte_o   <= VCO_CODE;
        phase_o      <= PH_VCO;
        data_valid_o <= 1'b0;
      end else if (byte_en_i) begin
        st_q          <= st_d;
        out_byte_o    <= byte_d;
        phase_o       <= ph_d;
        data_valid_o  <= (ph_d == PH_DATA);
        pc_init_stb_o <= stb_d;
        if (stb_d) pc_init_val_o <= pc_pol_i;
      end
    end
  end
endmodule

// File: rtl/wr_preamble_seq.sv
module wr_preamble_seq
  import wps_pkg::*;
#(
  parameter int AUTO_TRAIN_LEN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_en_i,
  input  logic              wg_i,
  input  logic [BYTE_W-1:0] nrz_i,
  input  logic              semi_auto_i,
  input  logic              dual_sync_i,
  input  logic              test_mode_i,
  input  logic              pc_preset_dis_i,
  input  logic              pc_pol_i,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic [1:0]        phase_o,
  output logic              data_valid_o,
  output logic              pc_init_stb_o,
  output logic              pc_init_val_o
);
  logic   hit_train, hit_mark1, hit_mark, hit_auto;
  logic   cnt_ld, cnt_inc, cnt_done;
  phase_e phase;

  wps_trig_det u_det (
    .nrz_i       (nrz_i),
    .hit_train_o (hit_train),
    .hit_mark1_o (hit_mark1),
    .hit_mark_o  (hit_mark),
    .hit_auto_o  (hit_auto)
  );

  wps_auto_cnt #(.LEN(AUTO_TRAIN_LEN)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (cnt_ld),
    .inc_i  (cnt_inc),
    .done_o (cnt_done)
  );

  wps_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .byte_en_i     (byte_en_i),
    .wg_i          (wg_i),
    .nrz_i         (nrz_i),
    .semi_auto_i   (semi_auto_i),
    .dual_sync_i   (dual_sync_i),
    .preset_en_i   (!test_mode_i && !pc_preset_dis_i),
    .pc_pol_i      (pc_pol_i),
    .hit_train_i   (hit_train),
    .hit_mark1_i   (hit_mark1),
    .hit_mark_i    (hit_mark),
    .hit_auto_i    (hit_auto),
    .cnt_done_i    (cnt_done),
    .cnt_ld_o      (cnt_ld),
    .cnt_inc_o     (cnt_inc),
    .out_byte_o    (out_byte_o),
    .phase_o       (phase),
    .data_valid_o  (data_valid_o),
    .pc_init_stb_o (pc_init_stb_o),
    .pc_init_val_o (pc_init_val_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/wps_chk.sv
module wps_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_en_i,
  input logic       wg_i,
  input logic       test_mode_i,
  input logic       pc_preset_dis_i,
  input logic       pc_pol_i,
  input logic [7:0] out_byte_o,
  input logic [1:0] phase_o,
  input logic       data_valid_o,
  input logic       pc_init_stb_o,
  input logic       pc_init_val_o
);
  // R8
  wg_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wg_i |=> (phase_o == 2'd0 && !data_valid_o && out_byte_o == 8'h00));

  // R7
  dv_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> phase_o == 2'd3);

  // R9
  stb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_init_stb_o |=> !pc_init_stb_o);

  // R9
  stb_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_init_stb_o |-> (phase_o == 2'd1 && out_byte_o == 8'h93
                       && pc_init_val_o == $past(pc_pol_i)));

  // R10
  stb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_init_stb_o |-> (!$past(test_mode_i) && !$past(pc_preset_dis_i)));

  // R4
  mark_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 2'd2 |-> (out_byte_o == 8'h69 || out_byte_o == 8'h1F));

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wg_i && $past(wg_i) && !$past(byte_en_i))
      |-> ($stable(out_byte_o) && $stable(phase_o)));
endmodule

bind wr_preamble_seq wps_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .byte_en_i       (byte_en_i),
  .wg_i            (wg_i),
  .test_mode_i     (test_mode_i),
  .pc_preset_dis_i (pc_preset_dis_i),
  .pc_pol_i        (pc_pol_i),
  .out_byte_o      (out_byte_o),
  .phase_o         (phase_o),
  .data_valid_o    (data_valid_o),
  .pc_init_stb_o   (pc_init_stb_o),
  .pc_init_val_o   (pc_init_val_o)
);

// File: tb/wr_preamble_seq_bench.sv
`timescale 1ns/1ps
module wr_preamble_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_en = 1'b0;
  logic       wg = 1'b0;
  logic [7:0] nrz = 8'h00;
  logic       semi = 1'b0, dual = 1'b0, tm = 1'b0, dis = 1'b0, pol = 1'b0;
  logic [7:0] out_byte;
  logic [1:0] phase;
  logic       dv, stb, val;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  typedef struct {
    logic [7:0] b;
    logic [1:0] ph;
    logic       dv;
    logic       stb;
    logic       val;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  wr_preamble_seq u_wr_preamble_seq (
    .clk_i(clk), .rst_ni(rst_n), .byte_en_i(byte_en), .wg_i(wg), .nrz_i(nrz),
    .semi_auto_i(semi), .dual_sync_i(dual), .test_mode_i(tm),
    .pc_preset_dis_i(dis), .pc_pol_i(pol),
    .out_byte_o(out_byte), .phase_o(phase), .data_valid_o(dv),
    .pc_init_stb_o(stb), .pc_init_val_o(val)
  );

  task automatic send(input logic [7:0] d, input logic [7:0] eb, input logic [1:0] eph,
                      input logic es, input logic ev, input string req);
    exp_t e;
    @(negedge clk);
    nrz = d;
    byte_en = 1'b1;
    e.b = eb; e.ph = eph; e.dv = (eph == 2'd3); e.stb = es; e.val = ev; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    byte_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_idle(input string req);
    n_chk++;
    if (out_byte !== 8'h00 || phase !== 2'd0 || dv !== 1'b0 || stb !== 1'b0) begin
      n_fail++;
      $display("FAIL %s idle: byte=%h ph=%0d dv=%b stb=%b exp byte=00 ph=0 dv=0 stb=0",
               req, out_byte, phase, dv, stb);
    end
  endtask

  task automatic drop_wg(input string req);
    @(negedge clk);
    wg = 1'b0;
    @(negedge clk);
    check_idle(req);
  endtask

  // monitor
  initial begin
    forever begin
      logic fire;
      @(posedge clk);
      fire = byte_en;
      @(negedge clk);
      if (fire) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL scoreboard: output with no expected item");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (out_byte !== e.b || phase !== e.ph || dv !== e.dv || stb !== e.stb ||
              (e.stb && val !== e.val)) begin
            n_fail++;
            $display("FAIL %s: byte=%h ph=%0d dv=%b stb=%b val=%b exp byte=%h ph=%0d dv=%b stb=%b val=%b",
                     e.req, out_byte, phase, dv, stb, val, e.b, e.ph, e.dv, e.stb, e.val);
          end
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // manual, single sync, preset with polarity 1
    pol = 1'b1;
    wg = 1'b1;
    for (int i = 0; i < 8; i++) send(8'h00, 8'h00, 2'd0, 1'b0, 1'b0, "R2");
    send(8'hFF, 8'h00, 2'd0, 1'b0, 1'b0, "R6 manual FF no trigger");
    send(8'h93, 8'h93, 2'd1, 1'b1, 1'b1, "R3 R9 first training");
    for (int i = 0; i < 4; i++) send(8'h93, 8'h93, 2'd1, 1'b0, 1'b0, "R3");
    send(8'h55, 8'h93, 2'd1, 1'b0, 1'b0, "R3 other byte");
    send(8'h1F, 8'h93, 2'd1, 1'b0, 1'b0, "R4 1F in single");
    send(8'h69, 8'h69, 2'd2, 1'b0, 1'b0, "R4 sync mark");
    send(8'hA5, 8'hA5, 2'd3, 1'b0, 1'b0, "R7");
    send(8'h3C, 8'h3C, 2'd3, 1'b0, 1'b0, "R7");
    send(8'h69, 8'h69, 2'd3, 1'b0, 1'b0, "R7");
    send(8'h93, 8'h93, 2'd3, 1'b0, 1'b0, "R7");
    nrz = 8'h11;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_byte !== 8'h93 || phase !== 2'd3) begin
      n_fail++;
      $display("FAIL R11 hold: byte=%h ph=%0d exp byte=93 ph=3", out_byte, phase);
    end
    drop_wg("R8 from data");

    // manual, dual sync, polarity 0
    dual = 1'b1; pol = 1'b0;
    wg = 1'b1;
    for (int i = 0; i < 8; i++) send(8'h00, 8'h00, 2'd0, 1'b0, 1'b0, "R2");
    send(8'h93, 8'h93, 2'd1, 1'b1, 1'b0, "R9 reset polarity");
    for (int i = 0; i < 3; i++) send(8'h93, 8'h93, 2'd1, 1'b0, 1'b0, "R3");
    send(8'h69, 8'h93, 2'd1, 1'b0, 1'b0, "R5 69 in dual training");
    send(8'h1F, 8'h1F, 2'd2, 1'b0, 1'b0, "R5 first mark");
    send(8'h00, 8'h93, 2'd1, 1'b0, 1'b0, "R5 propagation");
    send(8'h12, 8'h93, 2'd1, 1'b0, 1'b0, "R5 tail training");
    send(8'h69, 8'h69, 2'd2, 1'b0, 1'b0, "R5 second mark");
    send(8'h01, 8'h01, 2'd3, 1'b0, 1'b0, "R7");
    send(8'hFE, 8'hFE, 2'd3, 1'b0, 1'b0, "R7");
    drop_wg("R8 from dual data");

    // semi-automatic, polarity 1
    semi = 1'b1; dual = 1'b0; pol = 1'b1;
    wg = 1'b1;
    for (int i = 0; i < 8; i++) send(8'h00, 8'h00, 2'd0, 1'b0, 1'b0, "R2");
    send(8'h93, 8'h00, 2'd0, 1'b0, 1'b0, "R6 93 no trigger");
    send(8'hFF, 8'h93, 2'd1, 1'b1, 1'b1, "R6 R9 trigger");
    send(8'h69, 8'h93, 2'd1, 1'b0, 1'b0, "R6 ignored");
    send(8'h1F, 8'h93, 2'd1, 1'b0, 1'b0, "R6 ignored");
    send(8'h00, 8'h93, 2'd1, 1'b0, 1'b0, "R6 ignored");
    send(8'h69, 8'h93, 2'd1, 1'b0, 1'b0, "R6 fifth training");
    send(8'hAA, 8'h69, 2'd2, 1'b0, 1'b0, "R6 auto mark");
    send(8'hC3, 8'hC3, 2'd3, 1'b0, 1'b0, "R7");
    drop_wg("R8 from semi data");

    // semi run cut short by write gate
    wg = 1'b1;
    send(8'hFF, 8'h93, 2'd1, 1'b1, 1'b1, "R6 trigger");
    send(8'h00, 8'h93, 2'd1, 1'b0, 1'b0, "R6");
    drop_wg("R8 from auto training");
    wg = 1'b1;
    send(8'h00, 8'h00, 2'd0, 1'b0, 1'b0, "R8 restart in timing field");
    drop_wg("R8");

    // test mode blocks preset
    semi = 1'b0; tm = 1'b1;
    wg = 1'b1;
    send(8'h00, 8'h00, 2'd0, 1'b0, 1'b0, "R2");
    send(8'h93, 8'h93, 2'd1, 1'b0, 1'b0, "R10 test mode");
    send(8'h93, 8'h93, 2'd1, 1'b0, 1'b0, "R10");
    drop_wg("R8 from training");

    // disable bit blocks preset
    tm = 1'b0; dis = 1'b1;
    wg = 1'b1;
    send(8'h93, 8'h93, 2'd1, 1'b0, 1'b0, "R10 preset disabled");
    send(8'h69, 8'h69, 2'd2, 1'b0, 1'b0, "R4");
    drop_wg("R8");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: %0d expected items left, exp 0", exp_q.size());
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule